// File: doc/BRIEF.md
# Permission-Checking Translation Cache

This block keeps recently used virtual-to-physical page translations so that most memory accesses avoid a page-table walk. A 20-bit virtual page number is split into a 4-bit set index (its low bits) and a 16-bit tag. The index selects one of 16 sets, and the four ways of that set are compared against the tag. Each stored translation carries a 20-bit physical page number and four attribute bits: global, supervisor-only, writable, and dirty-already-marked.

A lookup reports one of three outcomes. A usable hit returns the physical page number. A protection fault is reported when the access breaks the entry's permissions. Any other case is a miss, which sends the access to the page walker. A write to an entry that has not been marked dirty is also reported as a miss, so that the walker sets the dirty bit in memory exactly once. The walker then refills the entry with the dirty attribute set. A refill of a translation that is already cached overwrites that entry in place. A new translation goes into the lowest free way, or, when the set is full, into the way named by a per-set round-robin pointer. On a task switch, a flush command drops every entry that is not global. A status vector shows, for every entry, whether it is valid and dirty-marked.

Top module: `tlb_perm_cache`

## Requirements
- R1: After reset every entry is invalid. Any lookup misses, `res_valid` is low, and `dirty_map` is all zero.
- R2: The set is `vpn[3:0]` and the tag is `vpn[19:4]`. A lookup finds an entry only if a valid way of that set holds the same tag. The same tag in another set, or another tag in the same set, misses.
- R3: A request presented while `lk_valid` is high is captured at clock edge k. Its result appears on `res_*` from edge k+1 and lasts for one cycle, with `res_valid` high for that cycle only.
- R4: On a usable hit, `res_ppn` is the stored physical page number. In every other cycle, `res_ppn` is zero.
- R5: A matching entry gives `res_fault`=1 and `res_hit`=0 when `lk_user`=1 and the entry is supervisor-only, or when `lk_write`=1 and the entry is not writable. A fault is never reported without a tag match.
- R6: A permitted write to a matching entry whose dirty-marked bit is clear gives `res_hit`=0 and `res_fault`=0 (a miss). After a refill with the dirty attribute set, the same write hits. Reads hit whatever the dirty bit holds.
- R7: A `flush_local` pulse invalidates every entry whose global bit is clear and leaves global entries usable.
- R8: A fill whose tag is already valid in its set rewrites that way. Otherwise it takes the lowest-numbered invalid way. In a full set it takes the way named by the set's round-robin pointer, which resets to 0 and advances by one after each such replacement.
- R9: A fill in the same cycle as a lookup to the same set is visible to that lookup. A fill in the same cycle as a flush survives the flush.
- R10: `dirty_map` bit `set*4+way` is 1 exactly when that entry is valid and its dirty-marked attribute is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made in user mode |
| fill_valid | input | 1 | Write a translation from the page walker |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_global | input | 1 | Fill attribute: survives a task-switch flush |
| fill_super | input | 1 | Fill attribute: supervisor-only page |
| fill_writable | input | 1 | Fill attribute: writes permitted |
| fill_dirty | input | 1 | Fill attribute: dirty already marked in memory |
| flush_local | input | 1 | Invalidate all non-global entries |
| res_valid | output | 1 | Lookup result is present |
| res_hit | output | 1 | Usable translation found |
| res_fault | output | 1 | Permission violation on a matching entry |
| res_ppn | output | 20 | Physical page number on a hit, else zero |
| dirty_map | output | 64 | Per-entry valid-and-dirty-marked status |

## Verification
Two pairs of operations can land in the same cycle. A page-walker fill can coincide with a lookup to the same set, and a fill can coincide with a task-switch flush. The first pair is provoked by raising `fill_valid` and `lk_valid` on the same clock for a translation that is not yet cached; it passes only if that lookup returns a hit with the new page number. The second pair is provoked by pulsing the flush together with a non-global fill; it is judged from `dirty_map`, which must show the new entry alive and every older non-global entry gone.

// File: rtl/tlb_perm_cache.sv
module tlb_perm_cache #(
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 20,
  parameter int SET_BITS = 4,
  parameter int WAYS     = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            lk_valid,
  input  logic [VPN_W-1:0]                lk_vpn,
  input  logic                            lk_write,
  input  logic                            lk_user,
  input  logic                            fill_valid,
  input  logic [VPN_W-1:0]                fill_vpn,
  input  logic [PPN_W-1:0]                fill_ppn,
  input  logic                            fill_global,
  input  logic                            fill_super,
  input  logic                            fill_writable,
  input  logic                            fill_dirty,
  input  logic                            flush_local,
  output logic                            res_valid,
  output logic                            res_hit,
  output logic                            res_fault,
  output logic [PPN_W-1:0]                res_ppn,
  output logic [(1<<SET_BITS)*WAYS-1:0]   dirty_map
);
  localparam int SETS    = 1 << SET_BITS;
  localparam int TAG_W   = VPN_W - SET_BITS;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int IDX_W   = SET_BITS + WAY_W;
  localparam int ENTRIES = SETS * WAYS;

  logic [ENTRIES-1:0] vld, glb, sup, wrt, drt;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [WAY_W-1:0]   rr_q  [SETS];

  // fill placement: matching way, else lowest free way, else round robin
  wire [SET_BITS-1:0] f_set = fill_vpn[SET_BITS-1:0];
  wire [TAG_W-1:0]    f_tag = fill_vpn[VPN_W-1:SET_BITS];
  logic               m_hit, i_any;
  logic [WAY_W-1:0]   m_way, i_way, f_way;
  logic [IDX_W-1:0]   f_idx;

  always_comb begin
    m_hit = 1'b0;
    i_any = 1'b0;
    m_way = '0;
    i_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[{f_set, WAY_W'(w)}] && tag_q[{f_set, WAY_W'(w)}] == f_tag) begin
        m_hit = 1'b1;
        m_way = WAY_W'(w);
      end
      if (!vld[{f_set, WAY_W'(w)}]) begin
        i_any = 1'b1;
        i_way = WAY_W'(w);
      end
    end
    f_way = m_hit ? m_way : (i_any ? i_way : rr_q[f_set]);
  end
  assign f_idx = {f_set, f_way};

  // registered request, compared against the array after the capture edge
  logic             req_v, req_wr, req_usr;
  logic [VPN_W-1:0] req_vpn;
  wire [SET_BITS-1:0] r_set = req_vpn[SET_BITS-1:0];
  wire [TAG_W-1:0]    r_tag = req_vpn[VPN_W-1:SET_BITS];
  logic               r_match;
  logic [IDX_W-1:0]   r_idx;

  always_comb begin
    r_match = 1'b0;
    r_idx   = {r_set, {WAY_W{1'b0}}};
    for (int w = 0; w < WAYS; w++) begin
      if (vld[{r_set, WAY_W'(w)}] && tag_q[{r_set, WAY_W'(w)}] == r_tag) begin
        r_match = 1'b1;
        r_idx   = {r_set, WAY_W'(w)};
      end
    end
  end

  wire perm_bad  = (req_usr & sup[r_idx]) | (req_wr & ~wrt[r_idx]);
  wire need_walk = req_wr & ~drt[r_idx];
  wire lk_hit    = req_v & r_match & ~perm_bad & ~need_walk;
  wire lk_fault  = req_v & r_match & perm_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      req_v     <= 1'b0;
      req_wr    <= 1'b0;
      req_usr   <= 1'b0;
      req_vpn   <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
      res_ppn   <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      req_v <= lk_valid;
      if (lk_valid) begin
        req_vpn <= lk_vpn;
        req_wr  <= lk_write;
        req_usr <= lk_user;
      end
      res_valid <= req_v;
      res_hit   <= lk_hit;
      res_fault <= lk_fault;
      res_ppn   <= lk_hit ? ppn_q[r_idx] : '0;
      if (flush_local) vld <= vld & glb;
      if (fill_valid) begin
        vld[f_idx] <= 1'b1;
        if (!m_hit && !i_any) rr_q[f_set] <= rr_q[f_set] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[f_idx] <= f_tag;
      ppn_q[f_idx] <= fill_ppn;
      glb[f_idx]   <= fill_global;
      sup[f_idx]   <= fill_super;
      wrt[f_idx]   <= fill_writable;
      drt[f_idx]   <= fill_dirty;
    end
  end

  assign dirty_map = vld & drt;

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_hit && res_fault)); // R5
  AST_PPN_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> res_ppn == '0); // R4
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##2 res_valid); // R3
  AST_FLUSH_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !fill_valid) |=> ((vld & ~glb) == '0)); // R7
  AST_FILL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> dirty_map[$past(f_idx)] == $past(fill_dirty)); // R10
endmodule

// File: tb/tlb_perm_cache_test.sv
`timescale 1ns/1ps
module tlb_perm_cache_test;
  logic        clk, rst_n;
  logic        lk_valid, lk_write, lk_user;
  logic [19:0] lk_vpn;
  logic        fill_valid, fill_global, fill_super, fill_writable, fill_dirty;
  logic [19:0] fill_vpn, fill_ppn;
  logic        flush_local;
  logic        res_valid, res_hit, res_fault;
  logic [19:0] res_ppn;
  logic [63:0] dirty_map;

  int total = 0;
  int bad   = 0;

  tlb_perm_cache uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_user(lk_user),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_global(fill_global), .fill_super(fill_super),
    .fill_writable(fill_writable), .fill_dirty(fill_dirty),
    .flush_local(flush_local),
    .res_valid(res_valid), .res_hit(res_hit), .res_fault(res_fault),
    .res_ppn(res_ppn), .dirty_map(dirty_map)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {op(1=fill), vpn, ppn, attr, exp_hit, exp_fault}
  // fill attr = {global, super, writable, dirty}; lookup attr = {0, 0, write, user}
  localparam int NV = 13;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 20'h12345, 20'hAAAAA, 4'b0010, 1'b0, 1'b0},
    {1'b0, 20'h12345, 20'hAAAAA, 4'b0001, 1'b1, 1'b0},
    {1'b0, 20'h12345, 20'h00000, 4'b0011, 1'b0, 1'b0},
    {1'b1, 20'h12345, 20'hAAAAA, 4'b0011, 1'b0, 1'b0},
    {1'b0, 20'h12345, 20'hAAAAA, 4'b0011, 1'b1, 1'b0},
    {1'b1, 20'h00016, 20'h0BEEF, 4'b1101, 1'b0, 1'b0},
    {1'b0, 20'h00016, 20'h00000, 4'b0001, 1'b0, 1'b1},
    {1'b0, 20'h00016, 20'h0BEEF, 4'b0000, 1'b1, 1'b0},
    {1'b0, 20'h00016, 20'h00000, 4'b0010, 1'b0, 1'b1},
    {1'b0, 20'h00026, 20'h00000, 4'b0000, 1'b0, 1'b0},
    {1'b0, 20'h12346, 20'h00000, 4'b0000, 1'b0, 1'b0},
    {1'b0, 20'h12355, 20'h00000, 4'b0000, 1'b0, 1'b0},
    {1'b0, 20'h12345, 20'hAAAAA, 4'b0000, 1'b1, 1'b0}
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] a,
                         input logic fl);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = p;
    {fill_global, fill_super, fill_writable, fill_dirty} = a;
    flush_local = fl;
    @(negedge clk);
    fill_valid = 1'b0; flush_local = 1'b0;
  endtask

  task automatic do_look(input string rq, input logic [19:0] v, input logic wr, input logic usr,
                         input logic eh, input logic ef, input logic [19:0] ep);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    chk(rq, {41'd0, res_valid, res_hit, res_fault, res_ppn}, {41'd0, 1'b1, eh, ef, ep});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R3 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; lk_write = 1'b0; lk_user = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; flush_local = 1'b0;
    {fill_global, fill_super, fill_writable, fill_dirty} = 4'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 res_valid after reset", {63'd0, res_valid}, 64'd0);
    chk("R1 dirty_map after reset", dirty_map, 64'd0);
    do_look("R1 lookup after reset", 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0);

    // table: R2 R4 R5 R6 lookups and fills
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46])
        do_fill(VEC[i][45:26], VEC[i][25:6], VEC[i][5:2], 1'b0);
      else
        do_look($sformatf("R2 R4 R5 R6 vector %0d", i), VEC[i][45:26], VEC[i][3], VEC[i][2],
                VEC[i][1], VEC[i][0], VEC[i][25:6]);
    end
    chk("R10 in-place refill marks set 5 way 0", dirty_map, 64'h0000_0000_0110_0000);

    // R3 result timing
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 20'h00016; lk_write = 1'b0; lk_user = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R3 no result one edge after capture edge", {63'd0, res_valid}, 64'd0);
    @(negedge clk);
    chk("R3 result present", {43'd0, res_valid, res_ppn}, {43'd0, 1'b1, 20'h0BEEF});
    @(negedge clk);
    chk("R3 result lasts one cycle", {63'd0, res_valid}, 64'd0);

    // R8 placement in set 3
    do_fill(20'h00013, 20'h11111, 4'b0011, 1'b0);
    do_fill(20'h00023, 20'h22222, 4'b0011, 1'b0);
    do_fill(20'h00033, 20'h33333, 4'b0011, 1'b0);
    do_fill(20'h00043, 20'h44444, 4'b0011, 1'b0);
    chk("R8 free ways filled lowest first", {60'd0, dirty_map[15:12]}, 64'hF);
    do_fill(20'h00053, 20'h55555, 4'b0010, 1'b0);
    chk("R8 first replacement takes way 0", {60'd0, dirty_map[15:12]}, 64'hE);
    do_look("R8 evicted way 0 misses", 20'h00013, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0);
    do_fill(20'h00063, 20'h66666, 4'b0010, 1'b0);
    chk("R8 second replacement takes way 1", {60'd0, dirty_map[15:12]}, 64'hC);
    do_look("R8 evicted way 1 misses", 20'h00023, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0);
    do_look("R8 survivor way 2 hits", 20'h00033, 1'b0, 1'b0, 1'b1, 1'b0, 20'h33333);
    do_look("R8 new entry hits", 20'h00053, 1'b0, 1'b0, 1'b1, 1'b0, 20'h55555);

    // R7 task-switch flush
    @(negedge clk);
    flush_local = 1'b1;
    @(negedge clk);
    flush_local = 1'b0;
    chk("R7 R10 only global entry left", dirty_map, 64'h0000_0000_0100_0000);
    do_look("R7 non-global entry gone", 20'h12345, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0);
    do_look("R7 global entry kept", 20'h00016, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0BEEF);

    // R9 flush and fill in the same cycle
    do_fill(20'h00777, 20'h77777, 4'b0011, 1'b1);
    chk("R9 fill survives simultaneous flush", dirty_map, 64'h0000_0000_1100_0000);

    // R9 fill and lookup in the same cycle, same set
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h0ABC7; fill_ppn = 20'h0C0DE;
    {fill_global, fill_super, fill_writable, fill_dirty} = 4'b0010;
    lk_valid = 1'b1; lk_vpn = 20'h0ABC7; lk_write = 1'b0; lk_user = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    @(negedge clk);
    chk("R9 lookup sees same-cycle fill", {41'd0, res_valid, res_hit, res_fault, res_ppn},
        {41'd0, 1'b1, 1'b1, 1'b0, 20'h0C0DE});
    do_look("R6 write to clean entry walks", 20'h0ABC7, 1'b1, 1'b1, 1'b0, 1'b0, 20'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule